// File: doc/BRIEF.md
# Selectable Infrared Carrier Generator

This block drives the infrared emitter output of a remote-control transmitter. It derives a carrier from the system clock and gates it with a single output data bit. A 3-bit select code picks the carrier. Six codes give a fixed divide ratio and high time: divide by 12, by 8 or by 11, at several duty fractions. The other two codes give no carrier, so the pin is a plain level that copies the data bit.

Software loads the select code first and then writes the data bit. The data bit is bit 3 of a 4-bit write value. When the data bit rises, the carrier phase restarts, so the first burst period is always complete. A new select code waits for the end of the running period, so no shortened pulse can appear. A stop input releases the pin by deasserting its output enable, which models the open-drain transistor turning off.

Top module: `ir_carrier_gen`

## Requirements
- R1: While `rst` is high, `pin_out` and `pin_oe` are 0. Reset leaves the select code at 000 and the data bit at 0.
- R2: Select code 000 gives a period of 12 clocks with 6 clocks high.
- R3: Select code 001 gives 12 clocks with 4 high. Select code 010 gives 12 clocks with 3 high.
- R4: Select code 011 gives 8 clocks with 4 high. Select code 100 gives 8 clocks with 2 high.
- R5: Select code 101 gives 11 clocks with 4 high.
- R6: Select codes 110 and 111 produce no carrier: `pin_out` is held at the data bit.
- R7: Only bit 3 of `dat_val` is stored as the data bit when `dat_wr` is high. Bits 2..0 have no effect. While the data bit is 0, `pin_out` is 0.
- R8: When the data bit goes from 0 to 1, the phase restarts at zero. `pin_out` rises on the second clock edge after the write, and the high part of a full period comes first. Writing 1 while the data bit is already 1 does not restart the phase.
- R9: A select code loaded with `sel_load` takes effect at the end of the current carrier period. While the data bit is 0 it takes effect at once.
- R10: `pin_oe` is the inverse of `stop`, registered once. `stop` does not change `pin_out` or the carrier phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_load | input | 1 | Load strobe for the select code |
| sel_val | input | 3 | Carrier select code |
| dat_wr | input | 1 | Write strobe for the output data register |
| dat_val | input | 4 | Write value; bit 3 is the data bit |
| stop | input | 1 | Stop mode; releases the pin |
| pin_out | output | 1 | Registered pin drive value |
| pin_oe | output | 1 | Registered output enable (0 = high impedance) |

## Verification
The in-RTL assertions check on every cycle that the pin stays low while the data bit is clear. They also check that the phase stays inside the active period, that the active select changes only at a period boundary or while idle, that a rising data bit starts the next cycle at phase zero, and that stop releases the enable one cycle later. Only the bench scenarios can show the exact high and low counts of each divide ratio. The same holds for the complete first period after a rise, and for the hand-over of a mid-period select change to the following period. The bench shows these by comparing against a behavioural model on every clock and by counting high cycles over whole periods.

// File: rtl/irc_pkg.sv
package irc_pkg;

  localparam int PH_W = 4;

  typedef struct packed {
    logic [PH_W-1:0] per;
    logic [PH_W-1:0] hi;
    logic            modulated;
  } carrier_cfg_t;

  function automatic carrier_cfg_t decode_sel(input logic [2:0] code);
    carrier_cfg_t c;
    c.modulated = 1'b1;
    unique case (code)
      3'd0: begin c.per = 4'd12; c.hi = 4'd6; end
      3'd1: begin c.per = 4'd12; c.hi = 4'd4; end
      3'd2: begin c.per = 4'd12; c.hi = 4'd3; end
      3'd3: begin c.per = 4'd8;  c.hi = 4'd4; end
      3'd4: begin c.per = 4'd8;  c.hi = 4'd2; end
      3'd5: begin c.per = 4'd11; c.hi = 4'd4; end
      default: begin c.per = 4'd1; c.hi = 4'd1; c.modulated = 1'b0; end
    endcase
    return c;
  endfunction

endpackage

// File: rtl/carrier_select.sv
module carrier_select
  import irc_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SEL_W-1:0] val,
  input  logic             upd,
  output logic [SEL_W-1:0] sel_act,
  output carrier_cfg_t     cfg
);

  logic [SEL_W-1:0] sel_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_pend <= '0;
      sel_act  <= '0;
    end else begin
      if (load) sel_pend <= val;
      if (upd)  sel_act  <= sel_pend;
    end
  end

  assign cfg = decode_sel(sel_act[2:0]);

endmodule

// File: rtl/carrier_phase.sv
module carrier_phase
  import irc_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  carrier_cfg_t    cfg,
  output logic [PH_W-1:0] phase,
  output logic            wrap
);

  assign wrap = !run || (phase == cfg.per - 4'd1);

  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (wrap) phase <= '0;
    else           phase <= phase + 4'd1;
  end

  p_phase_range_r8: assert property (@(posedge clk) disable iff (rst)
    phase < cfg.per)
    else $error("phase outside active period");

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
  import irc_pkg::*;
#(
  parameter int SEL_W    = 3,
  parameter int WR_W     = 4,
  parameter int DATA_POS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_load,
  input  logic [SEL_W-1:0] sel_val,
  input  logic             dat_wr,
  input  logic [WR_W-1:0]  dat_val,
  input  logic             stop,
  output logic             pin_out,
  output logic             pin_oe
);

  logic             data_q;
  logic [PH_W-1:0]  phase;
  logic             wrap;
  logic [SEL_W-1:0] sel_act;
  carrier_cfg_t     cfg;
  logic             carrier;

  carrier_select #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst(rst), .load(sel_load), .val(sel_val),
    .upd(wrap), .sel_act(sel_act), .cfg(cfg)
  );

  carrier_phase u_ph (
    .clk(clk), .rst(rst), .run(data_q), .cfg(cfg),
    .phase(phase), .wrap(wrap)
  );

  always_ff @(posedge clk) begin
    if (rst)         data_q <= 1'b0;
    else if (dat_wr) data_q <= dat_val[DATA_POS];
  end

  assign carrier = !cfg.modulated || (phase < cfg.hi);

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end else begin
      pin_out <= data_q && carrier;
      pin_oe  <= !stop;
    end
  end

  p_idle_low_r7: assert property (@(posedge clk) disable iff (rst)
    !data_q |=> !pin_out)
    else $error("pin driven while data bit clear");

  p_rise_restart_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(data_q) |-> (phase == '0))
    else $error("phase not restarted on data rise");

  p_sel_boundary_r9: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_act) |-> $past(!data_q || (phase == cfg.per - 4'd1)))
    else $error("select changed inside a period");

  p_stop_oe_r10: assert property (@(posedge clk) disable iff (rst)
    stop |=> !pin_oe)
    else $error("enable not released in stop");

endmodule

// File: tb/sim_ir_carrier_gen.sv
`timescale 1ns/1ps
module sim_ir_carrier_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sel_load = 1'b0;
  logic [2:0] sel_val = 3'd0;
  logic       dat_wr = 1'b0;
  logic [3:0] dat_val = 4'd0;
  logic       stop = 1'b0;
  logic       pin_out, pin_oe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ir_carrier_gen u0 (
    .clk(clk), .rst(rst), .sel_load(sel_load), .sel_val(sel_val),
    .dat_wr(dat_wr), .dat_val(dat_val), .stop(stop),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic int per_of(int s);
    case (s)
      0, 1, 2: return 12;
      3, 4:    return 8;
      5:       return 11;
      default: return 1;
    endcase
  endfunction

  function automatic int hi_of(int s);
    case (s)
      0: return 6;
      1: return 4;
      2: return 3;
      3: return 4;
      4: return 2;
      5: return 4;
      default: return 1;
    endcase
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, updated at every rising edge
  int m_data = 0, m_phase = 0, m_pend = 0, m_act = 0;
  bit e_pin = 0, e_oe = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_data = 0; m_phase = 0; m_pend = 0; m_act = 0;
      e_pin = 0; e_oe = 0;
    end else begin
      int nd;
      bit edge_end;
      e_pin = (m_data != 0) && (m_act >= 6 || m_phase < hi_of(m_act));
      e_oe  = !stop;
      edge_end = (m_data == 0) || (m_phase == per_of(m_act) - 1);
      nd = dat_wr ? int'(dat_val[3]) : m_data;
      m_phase = edge_end ? 0 : m_phase + 1;
      if (edge_end) m_act = m_pend;
      m_data = nd;
      if (sel_load) m_pend = int'(sel_val);
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(pin_out == e_pin, "R9 model pin", pin_out, e_pin);
      chk(pin_oe == e_oe, "R10 model oe", pin_oe, e_oe);
    end
  end

  task automatic wr(logic [3:0] v);
    @(negedge clk); dat_wr = 1'b1; dat_val = v;
    @(negedge clk); dat_wr = 1'b0; dat_val = 4'd0;
  endtask

  task automatic ld(logic [2:0] s);
    @(negedge clk); sel_load = 1'b1; sel_val = s;
    @(negedge clk); sel_load = 1'b0;
  endtask

  // after wr(1): count highs over n samples; first sample is phase zero
  task automatic count_hi(int n, output int hits, output bit first);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) first = pin_out;
      if (pin_out) hits++;
    end
  endtask

  task automatic mode_test(int s, string req);
    int h; bit f;
    wr(4'h0); ld(3'(s)); wr(4'h8);
    count_hi(2 * per_of(s), h, f);
    chk(h == 2 * hi_of(s), req, h, 2 * hi_of(s));
    chk(f == 1'b1, "R8 first period starts high", f, 1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int h; bit f;
    repeat (3) @(negedge clk);
    chk(pin_out == 1'b0, "R1 reset pin", pin_out, 0);
    chk(pin_oe == 1'b0, "R1 reset oe", pin_oe, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(pin_oe == 1'b1, "R10 oe after reset", pin_oe, 1);

    // R7: lower bits ignored, data stays 0
    wr(4'h7);
    repeat (4) @(negedge clk);
    chk(pin_out == 1'b0, "R7 low bits ignored", pin_out, 0);

    mode_test(0, "R2 div12 half");
    mode_test(1, "R3 div12 third");
    mode_test(2, "R3 div12 quarter");
    mode_test(3, "R4 div8 half");
    mode_test(4, "R4 div8 quarter");
    mode_test(5, "R5 div11 4of11");

    // R6: no carrier codes
    wr(4'h0); ld(3'd6); wr(4'h8);
    count_hi(10, h, f);
    chk(h == 10, "R6 code 110 steady", h, 10);
    wr(4'h0); @(negedge clk); @(negedge clk);
    chk(pin_out == 1'b0, "R6 follows data low", pin_out, 0);
    ld(3'd7); wr(4'hF);
    count_hi(10, h, f);
    chk(h == 10, "R6 code 111 steady", h, 10);

    // R9: mid-period change waits for boundary
    wr(4'h0); ld(3'd0); wr(4'h8);
    h = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (pin_out) h++;
      if (i == 3) begin sel_load = 1'b1; sel_val = 3'd4; end
      if (i == 4) sel_load = 1'b0;
    end
    chk(h == 6, "R9 running period kept", h, 6);
    count_hi(8, h, f);
    chk(h == 2, "R9 new code next period", h, 2);

    // R8: rewriting 1 does not restart; R10 stop keeps phase
    wr(4'h0); ld(3'd0); wr(4'h8);
    repeat (2) @(negedge clk);
    dat_wr = 1'b1; dat_val = 4'h8; stop = 1'b1;
    @(negedge clk); dat_wr = 1'b0;
    chk(pin_oe == 1'b0, "R10 stop releases oe", pin_oe, 0);
    repeat (6) @(negedge clk);
    stop = 1'b0;
    repeat (3) @(negedge clk);
    chk(pin_oe == 1'b1, "R10 oe returns", pin_oe, 1);
    wr(4'h0);
    repeat (3) @(negedge clk);
    chk(pin_out == 1'b0, "R7 data clear low", pin_out, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule